// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block is a purely combinational adder of parameterized width (16, 32 or 64 bits). It adds two operands and a carry-in, and produces the sum together with a carry-out. The carry into every bit comes from a tree of lookahead units rather than from a ripple chain, so the logic depth grows with the logarithm of the width instead of linearly.

Each bit cell forms a propagate signal (the XOR of the two operand bits) and a generate signal (their AND). It also forms its sum bit as the propagate XOR the carry delivered to it. Lookahead units of up to four inputs condense four propagate/generate pairs into one group pair and pass it upward. On the way back down, each unit expands the carry it receives from its parent into the carries for its four children. In every unit, each carry is a sum of products of generate, propagate and the incoming carry, and never passes through a neighbouring carry.

The 16-bit build uses two lookahead levels. The 64-bit build uses three levels of four-input units. The 32-bit build has a two-input unit at its root. The top carry-in feeds the root, and the carry-out is derived from the root's group pair.

Top module: `hcla_adder`

## Requirements
- R1: The width parameter accepts only 16, 32 and 64, and any other value stops elaboration; each accepted width carries out of exactly its top bit (all-ones plus one gives sum 0 and carry-out 1).
- R2: For every operand pair and carry-in, `{cout, sum}` equals the arithmetic value `a + b + cin` taken at width+1 bits.
- R3: With one operand all ones, the other zero and `cin` = 1, the carry propagates through every group, giving sum 0 and `cout` 1.
- R4: With one operand all ones, the other zero and `cin` = 0, the sum is all ones and `cout` is 0.
- R5: With both operands zero, the sum equals `cin` in bit 0 with all other bits 0, and `cout` is 0.
- R6: A carry generated in bit 0 (a = 1, b = all ones, `cin` = 0) reaches the carry-out, giving sum 0 and `cout` 1.
- R7: A carry generated at any bit position j, followed by propagating bits up to the top, produces the correct result for every j from 0 to width-1, including positions that sit on 4-, 16- and 64-bit group boundaries.
- R8: When both operand top bits are 1, `cout` is 1 whatever the other inputs are; when both are 0, `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that is born low in the word and must cross every group and level of the tree, because that path goes through each group-propagate term at every level. Random operands almost never produce a propagate run longer than a few bits. The stimulus therefore builds such runs on purpose: it sweeps a single generating bit across every position, with propagating bits set above it, and it adds all-ones operands with and without a carry-in. These runs are applied at the same time to 16-, 32- and 64-bit instances, so that every shape of tree, including the two-input root, is exercised.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // fan-in of one lookahead unit
   localparam int GRP = 4;

   // number of signals present at tree level k for a w-bit adder
   function automatic int lvl_width(input int w, input int k);
      int n;
      n = w;
      for (int i = 0; i < k; i++) begin
         n = (n + GRP - 1) / GRP;
      end
      return n;
   endfunction

   // number of lookahead levels needed to reduce w signals to one
   function automatic int num_levels(input int w);
      int n;
      int l;
      n = w;
      l = 0;
      while (n > 1) begin
         n = (n + GRP - 1) / GRP;
         l++;
      end
      return l;
   endfunction

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic p_o,
   output logic g_o,
   output logic s_o
);

   always_comb begin
      p_o = a_i ^ b_i;
      g_o = a_i & b_i;
      s_o = p_o ^ c_i;
   end

   // a bit either passes a carry on or creates one, never both (R2)
   always_comb begin
      p_cell_excl_r2: assert (!(p_o && g_o))
         else $error("bit cell reports propagate and generate together");
   end

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
   parameter int N = 4
) (
   input  logic [N-1:0] p_i,
   input  logic [N-1:0] g_i,
   input  logic         c_i,
   output logic [N-1:0] c_o,
   output logic         gp_o,
   output logic         gg_o
);

   if (N < 1 || N > cla_pkg::GRP) begin : g_bad_fanin
      $error("cla_lookahead: fan-in N out of range");
   end

   // two-level carries: each c_o[i] is an OR of product terms only
   always_comb begin
      logic acc;
      logic term;
      c_o[0] = c_i;
      for (int i = 1; i < N; i++) begin
         acc = 1'b0;
         for (int j = 0; j < i; j++) begin
            term = g_i[j];
            for (int m = j + 1; m < i; m++) begin
               term = term & p_i[m];
            end
            acc = acc | term;
         end
         term = c_i;
         for (int m = 0; m < i; m++) begin
            term = term & p_i[m];
         end
         c_o[i] = acc | term;
      end
   end

   // group pair handed to the parent level
   always_comb begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < N; j++) begin
         term = g_i[j];
         for (int m = j + 1; m < N; m++) begin
            term = term & p_i[m];
         end
         acc = acc | term;
      end
      gg_o = acc;
      gp_o = &p_i;
   end

   always_comb begin
      // a group cannot both pass and create its carry (R2)
      p_group_excl_r2: assert (!(gp_o && gg_o))
         else $error("group reports propagate and generate together");
      // a fully propagating group hands the incoming carry to every child (R3)
      if (gp_o) begin
         for (int i = 0; i < N; i++) begin
            p_pass_through_r3: assert (c_o[i] == c_i)
               else $error("propagating group altered a carry");
         end
      end
      // a child that does not propagate decides the next carry alone (R7)
      for (int i = 1; i < N; i++) begin
         if (!p_i[i-1]) begin
            p_local_carry_r7: assert (c_o[i] == g_i[i-1])
               else $error("non-propagating child did not set next carry");
         end
      end
   end

endmodule

// File: rtl/hcla_adder.sv
module hcla_adder #(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);

   localparam int GRP = cla_pkg::GRP;
   localparam int L   = cla_pkg::num_levels(W);

   // R1: only the supported widths elaborate
   if (!(W == 16 || W == 32 || W == 64)) begin : g_bad_width
      $error("hcla_adder: W must be 16, 32 or 64");
   end

   for (genvar k = 0; k <= L; k++) begin : g_lvl
      localparam int NK = cla_pkg::lvl_width(W, k);
      logic [NK-1:0] pv;
      logic [NK-1:0] gv;
      logic [NK-1:0] cv;

      if (k == 0) begin : g_cells
         for (genvar i = 0; i < W; i++) begin : g_bit
            cla_bit_cell u_cell (
               .a_i (a[i]),
               .b_i (b[i]),
               .c_i (cv[i]),
               .p_o (pv[i]),
               .g_o (gv[i]),
               .s_o (sum[i])
            );
         end
      end else begin : g_units
         localparam int NB = cla_pkg::lvl_width(W, k - 1);
         for (genvar u = 0; u < NK; u++) begin : g_unit
            localparam int NU = ((NB - GRP * u) > GRP) ? GRP : (NB - GRP * u);
            cla_lookahead #(.N(NU)) u_la (
               .p_i  (g_lvl[k-1].pv[GRP*u +: NU]),
               .g_i  (g_lvl[k-1].gv[GRP*u +: NU]),
               .c_i  (cv[u]),
               .c_o  (g_lvl[k-1].cv[GRP*u +: NU]),
               .gp_o (pv[u]),
               .gg_o (gv[u])
            );
         end
      end

      if (k == L) begin : g_root
         assign cv[0] = cin;
      end
   end

   assign cout = g_lvl[L].gv[0] | (g_lvl[L].pv[0] & cin);

   always_comb begin
      if (a[W-1] && b[W-1]) begin
         p_msb_gen_r8: assert (cout)
            else $error("both top bits set but no carry-out");
      end
      if (!a[W-1] && !b[W-1]) begin
         p_msb_kill_r8: assert (!cout)
            else $error("both top bits clear but carry-out set");
      end
   end

endmodule

// File: tb/test_hcla_adder.sv
module test_hcla_adder;

   logic        clk = 1'b0;
   logic [63:0] a64 = '0;
   logic [63:0] b64 = '0;
   logic        cin = 1'b0;

   logic [63:0] s64;
   logic        co64;
   logic [31:0] s32;
   logic        co32;
   logic [15:0] s16;
   logic        co16;

   int checks   = 0;
   int failures = 0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #2 clk = ~clk;   // 250 MHz

   hcla_adder #(.W(64)) i_hcla_adder (
      .a(a64), .b(b64), .cin(cin), .sum(s64), .cout(co64));
   hcla_adder #(.W(32)) i_hcla_adder_w32 (
      .a(a64[31:0]), .b(b64[31:0]), .cin(cin), .sum(s32), .cout(co32));
   hcla_adder #(.W(16)) i_hcla_adder_w16 (
      .a(a64[15:0]), .b(b64[15:0]), .cin(cin), .sum(s16), .cout(co16));

   function automatic logic [64:0] ref_add(input int w, input logic [63:0] x,
                                           input logic [63:0] y, input logic c);
      logic [64:0] m;
      logic [64:0] r;
      m = (65'd1 << w) - 65'd1;
      r = ({1'b0, x} & m) + ({1'b0, y} & m) + {64'd0, c};
      return r & ((m << 1) | 65'd1);
   endfunction

   task automatic check(input string req, input int w, input logic [64:0] got,
                        input logic [64:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s width=%0d got=%h expected=%h", req, w, got, exp);
      end
   endtask

   // drive on the falling edge, compare one time unit after the rising edge
   task automatic apply_and_check(input string req, input logic [63:0] x,
                                  input logic [63:0] y, input logic c);
      @(negedge clk);
      a64 = x;
      b64 = y;
      cin = c;
      @(posedge clk);
      #1;
      check(req, 64, {co64, s64}, ref_add(64, x, y, c));
      check(req, 32, {32'd0, co32, s32}, ref_add(32, x, y, c));
      check(req, 16, {48'd0, co16, s16}, ref_add(16, x, y, c));
   endtask

   function automatic logic [63:0] next_rand(input logic [63:0] s);
      logic [63:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 7);
      t = t ^ (t << 17);
      return t;
   endfunction

   task automatic t_idle();            // R2: quiet inputs give a quiet result
      apply_and_check("R2", 64'd0, 64'd0, 1'b0);
   endtask

   task automatic t_zero_with_cin();   // R5
      apply_and_check("R5", 64'd0, 64'd0, 1'b1);
   endtask

   task automatic t_all_ones_cin();    // R3
      apply_and_check("R3", '1, 64'd0, 1'b1);
      apply_and_check("R3", 64'd0, '1, 1'b1);
   endtask

   task automatic t_all_ones_no_cin(); // R4
      apply_and_check("R4", '1, 64'd0, 1'b0);
      apply_and_check("R4", 64'd0, '1, 1'b0);
   endtask

   task automatic t_width_limits();    // R1: all ones plus one overflows at each width
      apply_and_check("R1", '1, 64'd1, 1'b0);
   endtask

   task automatic t_gen_bit0();        // R6
      apply_and_check("R6", 64'd1, '1, 1'b0);
   endtask

   task automatic t_gen_sweep();       // R7: generate at j, propagate above it
      for (int j = 0; j < 64; j++) begin
         apply_and_check("R7", ~64'd0 << j, 64'd1 << j, 1'b0);
         apply_and_check("R7", ~64'd0 << j, 64'd1 << j, 1'b1);
      end
   endtask

   task automatic t_msb_cases();       // R8
      apply_and_check("R8", 64'h8000_8000_8000_8000 | 64'h8000_0000_8000_8000,
                      64'h8000_0000_8000_8000, 1'b0);
      apply_and_check("R8", 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, 1'b1);
   endtask

   task automatic t_random();          // R2
      for (int n = 0; n < 3000; n++) begin
         logic [63:0] x;
         logic [63:0] y;
         rng = next_rand(rng);
         x = rng;
         rng = next_rand(rng);
         y = rng;
         apply_and_check("R2", x, y, rng[5]);
      end
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      t_idle();
      t_zero_with_cin();
      t_all_ones_cin();
      t_all_ones_no_cin();
      t_width_limits();
      t_gen_bit0();
      t_gen_sweep();
      t_msb_cases();
      t_random();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule